// File: doc/BRIEF.md
# BMC packet transmit serializer

This block drives one packet onto a single-wire link using biphase mark coding. Each data bit takes two half-bit cells. Every bit begins with a level change. A 1 bit changes level again at mid-bit, so its two cells differ. A 0 bit keeps its two cells equal.

A packet starts with a `start` pulse while the block is idle. The block first sends a fixed preamble of 64 alternating bits. It then requests 5-bit line symbols through a valid/ready handshake and codes each one into ten cells. The line level carries over from one symbol to the next. To close the packet, the block sends a final edge followed by a low trailer, and then releases the output enable.

The cell rate is the clock divided by `CELL_DIV`, which makes it twice the bit rate. At a 300 kbit/s link this gives a 600 kHz cell rate. Upstream logic supplies ready-made 5-bit symbols. The block does no symbol-table lookup and no checksum generation.

Top module: `bmc_tx_serializer`

## Requirements
- R1: While reset is high, and on the first clock after it, `line_out`, `line_oe`, `sym_ready` and `underrun` are all 0.
- R2: A `start` pulse sampled while idle makes `line_oe` high from the next clock, and the first cell appears on that clock. Every cell then holds for exactly `CELL_DIV` clocks.
- R3: The preamble is 128 cells. Cell k equals bit (k mod 8) of 0xB4, so the cells repeat the pattern 0,0,1,0,1,1,0,1. The first cell is low and the last cell is high.
- R4: `sym_ready` is high only in the last clock of the preamble, or of a symbol, when another symbol is wanted. A symbol transfers when `sym_valid` and `sym_ready` are both high. Its bit i (bit 0 first) becomes cells 2i and 2i+1. Cell 2i is the inverse of the cell before it. Cell 2i+1 equals cell 2i when the bit is 0 and is its inverse when the bit is 1.
- R5: A symbol transferred with `sym_last` high is the final symbol; no further `sym_ready` follows it.
- R6: After `MAX_SYMS` symbols (default 72) the packet closes even if `sym_last` was never given.
- R7: The closing sequence follows the last cell sent. If that cell was low, the block sends one high cell and then one low cell. If it was high, it sends two low cells. `TRAIL_CELLS` low cells (default 2) follow in both cases.
- R8: `line_oe` stays high through the last trailer cell and falls on the clock after it. While `line_oe` is low, `line_out` is low.
- R9: If `sym_ready` is high and `sym_valid` is low, `underrun` pulses high for exactly one clock. That clock is the first clock of the closing sequence, which then runs as in R7.
- R10: A `start` pulse while `line_oe` is high has no effect on the waveform being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a packet (acted on only while idle) |
| sym_valid | input | 1 | A symbol is offered |
| sym_data | input | 5 | Symbol bits, bit 0 sent first |
| sym_last | input | 1 | Offered symbol is the final one |
| sym_ready | output | 1 | Block takes the offered symbol in this clock |
| line_out | output | 1 | Coded cell level |
| line_oe | output | 1 | Line is driven |
| underrun | output | 1 | One-clock pulse: no symbol was offered when one was needed |

## Verification
Two things can fall in the same clock. A symbol handshake happens on the last clock of the preamble or of a symbol, in the same clock where the level of the last cell picks the polarity of the next symbol. A missing symbol at that moment instead makes the underrun pulse coincide with the choice of closing edge. Packets are sized and chosen so that they end on both a low and a high level, with and without underrun, and one packet starves right after the preamble. A cycle model in the bench predicts the line, enable, ready and underrun values for every clock, and these are compared against the outputs on every clock.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SYM,
        ST_FIN,
        ST_TRAIL
    } tx_state_e;

    localparam int SYM_BITS      = 5;
    localparam int SYM_CELLS     = 2 * SYM_BITS;
    localparam int PRE_CELLS     = 128;
    localparam int IDX_W         = $clog2(PRE_CELLS);
    localparam logic [7:0] PRE_PATTERN = 8'hB4;

    typedef logic [SYM_CELLS-1:0] sym_cells_t;

    // preamble cell at a given position within the repeating 8-cell pattern
    function automatic logic pre_cell(input logic [2:0] pos);
        return PRE_PATTERN[pos];
    endfunction

endpackage

// File: rtl/bmc_cell_timer.sv
module bmc_cell_timer #(
    parameter int CELL_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int DIV_W = (CELL_DIV > 2) ? $clog2(CELL_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CELL_DIV - 1);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == DIV_LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == DIV_LAST);

endmodule

// File: rtl/bmc_sym_coder.sv
module bmc_sym_coder
    import bmc_tx_pkg::*;
(
    input  logic [SYM_BITS-1:0] sym,
    input  logic                prev_level,
    output sym_cells_t          cells
);
    // pattern coded as if the line sat low before the symbol
    logic [SYM_BITS:0] ref_lvl;
    sym_cells_t        base;

    assign ref_lvl[0] = 1'b0;

    for (genvar i = 0; i < SYM_BITS; i++) begin : g_bit
        assign base[2*i]     = ~ref_lvl[i];
        assign base[2*i + 1] = sym[i] ? ref_lvl[i] : ~ref_lvl[i];
        assign ref_lvl[i+1]  = base[2*i + 1];
    end

    // polarity mask taken from the level actually on the line
    assign cells = base ^ {SYM_CELLS{prev_level}};

endmodule

// File: rtl/bmc_tx_serializer.sv
module bmc_tx_serializer
    import bmc_tx_pkg::*;
#(
    parameter int CELL_DIV    = 4,
    parameter int MAX_SYMS    = 72,
    parameter int TRAIL_CELLS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                sym_valid,
    input  logic [SYM_BITS-1:0] sym_data,
    input  logic                sym_last,
    output logic                sym_ready,
    output logic                line_out,
    output logic                line_oe,
    output logic                underrun
);
    localparam int CNT_W = $clog2(MAX_SYMS + 1);
    localparam logic [CNT_W-1:0] SYM_CAP    = MAX_SYMS[CNT_W-1:0];
    localparam logic [IDX_W-1:0] PRE_LAST   = IDX_W'(PRE_CELLS - 1);
    localparam logic [IDX_W-1:0] SYM_LAST   = IDX_W'(SYM_CELLS - 1);
    localparam logic [IDX_W-1:0] TRAIL_LAST = IDX_W'(TRAIL_CELLS - 1);

    tx_state_e        state;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_nx;
    sym_cells_t       cells_q;
    sym_cells_t       new_cells;
    logic             last_q;
    logic [CNT_W-1:0] nsyms;
    logic             line_q;
    logic             under_q;
    logic             tick;
    logic             block_end;
    logic             more_wanted;
    logic             take;

    bmc_cell_timer #(.CELL_DIV(CELL_DIV)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state != ST_IDLE),
        .tick (tick)
    );

    bmc_sym_coder u_coder (
        .sym        (sym_data),
        .prev_level (line_q),
        .cells      (new_cells)
    );

    assign idx_nx      = idx + 1'b1;
    assign block_end   = tick && (((state == ST_PRE) && (idx == PRE_LAST)) ||
                                  ((state == ST_SYM) && (idx == SYM_LAST)));
    assign more_wanted = (state == ST_PRE) || (!last_q && (nsyms != SYM_CAP));
    assign sym_ready   = block_end && more_wanted;
    assign take        = sym_ready && sym_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            idx     <= '0;
            cells_q <= '0;
            last_q  <= 1'b0;
            nsyms   <= '0;
            line_q  <= 1'b0;
            under_q <= 1'b0;
        end else begin
            under_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_PRE;
                        idx    <= '0;
                        line_q <= pre_cell(3'd0);
                        nsyms  <= '0;
                        last_q <= 1'b0;
                    end
                end
                ST_PRE, ST_SYM: begin
                    if (tick) begin
                        if (!block_end) begin
                            idx    <= idx_nx;
                            line_q <= (state == ST_PRE) ? pre_cell(idx_nx[2:0])
                                                        : cells_q[idx_nx[3:0]];
                        end else if (take) begin
                            state   <= ST_SYM;
                            idx     <= '0;
                            cells_q <= new_cells;
                            line_q  <= new_cells[0];
                            last_q  <= sym_last;
                            nsyms   <= nsyms + 1'b1;
                        end else begin
                            // closing edge: high then low after a low cell, else low
                            state   <= ST_FIN;
                            idx     <= '0;
                            line_q  <= ~line_q;
                            under_q <= sym_ready;
                        end
                    end
                end
                ST_FIN: begin
                    if (tick) begin
                        line_q <= 1'b0;
                        if (idx == '0) begin
                            idx <= idx_nx;
                        end else begin
                            state <= ST_TRAIL;
                            idx   <= '0;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        line_q <= 1'b0;
                        if (idx == TRAIL_LAST) begin
                            state <= ST_IDLE;
                            idx   <= '0;
                        end else begin
                            idx <= idx_nx;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign line_out = line_q;
    assign line_oe  = (state != ST_IDLE);
    assign underrun = under_q;

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !line_oe |-> !line_out); // R8

    AST_READY_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        sym_ready |-> line_oe); // R4

    AST_SYM_EDGE: assert property (@(posedge clk) disable iff (rst)
        (sym_ready && sym_valid) |=> (line_out != $past(line_out))); // R4

    AST_CELL_STEADY: assert property (@(posedge clk) disable iff (rst)
        (line_oe && $past(line_oe) && !$past(tick)) |-> $stable(line_out)); // R2

    AST_PRE_LOW_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(line_oe) |-> !line_out); // R3

    AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (rst)
        underrun |=> !underrun); // R9

    AST_UNDERRUN_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        underrun |-> (line_oe && !sym_ready)); // R9

endmodule

// File: tb/tb_bmc_tx_serializer.sv
module tb_bmc_tx_serializer;
    localparam int CLK_PERIOD  = 10;
    localparam int CELL_DIV    = 4;
    localparam int MAX_SYMS    = 72;
    localparam int TRAIL_CELLS = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       sym_valid = 1'b0;
    logic [4:0] sym_data = '0;
    logic       sym_last = 1'b0;
    logic       sym_ready;
    logic       line_out;
    logic       line_oe;
    logic       underrun;

    int n_checks = 0;
    int n_errors = 0;

    bit    q_line[$];
    bit    q_oe[$];
    bit    q_rdy[$];
    bit    q_und[$];
    string q_tag[$];
    logic [5:0] plan[$];
    logic [5:0] feed[$];
    bit pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bmc_tx_serializer #(
        .CELL_DIV(CELL_DIV), .MAX_SYMS(MAX_SYMS), .TRAIL_CELLS(TRAIL_CELLS)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .sym_valid(sym_valid),
        .sym_data(sym_data), .sym_last(sym_last), .sym_ready(sym_ready),
        .line_out(line_out), .line_oe(line_oe), .underrun(underrun)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic push_cell(input bit v, input bit rdy_end, input bit und_first,
                             input string tag);
        for (int r = 0; r < CELL_DIV; r++) begin
            q_line.push_back(v);
            q_oe.push_back(1'b1);
            q_rdy.push_back(rdy_end && (r == CELL_DIV - 1));
            q_und.push_back(und_first && (r == 0));
            q_tag.push_back(tag);
        end
    endtask

    // behavioural model: expected value for every clock of the packet
    task automatic build_model();
        bit lvl = 1'b1;
        bit c0, c1, more;
        bit und = 1'b0;
        bit ended = 1'b0;
        int taken = 0;
        for (int b = 0; b < 64; b++) begin
            c0 = ~lvl;
            c1 = (b % 2 == 1) ? ~c0 : c0;
            push_cell(c0, 1'b0, 1'b0, "R3");
            push_cell(c1, b == 63, 1'b0, "R3");
            lvl = c1;
        end
        while (!ended) begin
            if (taken >= plan.size()) begin
                und = 1'b1;
                ended = 1'b1;
            end else begin
                logic [5:0] s = plan[taken];
                taken++;
                more = !s[5] && (taken < MAX_SYMS);
                for (int i = 0; i < 5; i++) begin
                    c0 = ~lvl;
                    c1 = s[i] ? ~c0 : c0;
                    push_cell(c0, 1'b0, 1'b0, "R4");
                    push_cell(c1, (i == 4) && more, 1'b0, s[5] ? "R5" : "R6");
                    lvl = c1;
                end
                if (!more) ended = 1'b1;
            end
        end
        push_cell(~lvl, 1'b0, und, und ? "R9" : "R7");
        push_cell(1'b0, 1'b0, 1'b0, "R7");
        for (int t = 0; t < TRAIL_CELLS; t++) push_cell(1'b0, 1'b0, 1'b0, "R8");
    endtask

    // one clock: feed symbols, compare every output, then set start
    task automatic step(input bit do_start);
        bit el, eo, er, eu;
        string tg;
        @(negedge clk);
        if (pend) begin
            void'(feed.pop_front());
            pend = 1'b0;
        end
        sym_valid = (feed.size() > 0);
        sym_data  = (feed.size() > 0) ? feed[0][4:0] : 5'd0;
        sym_last  = (feed.size() > 0) ? feed[0][5] : 1'b0;
        if (sym_ready && sym_valid) pend = 1'b1;
        if (q_line.size() > 0) begin
            el = q_line.pop_front(); eo = q_oe.pop_front();
            er = q_rdy.pop_front();  eu = q_und.pop_front();
            tg = q_tag.pop_front();
        end else begin
            el = 0; eo = 0; er = 0; eu = 0; tg = "R8";
        end
        chk(line_out == el, tg, "line_out", int'(line_out), int'(el));
        chk(line_oe == eo, tg, "line_oe", int'(line_oe), int'(eo));
        chk(sym_ready == er, er ? "R4" : tg, "sym_ready", int'(sym_ready), int'(er));
        chk(underrun == eu, "R9", "underrun", int'(underrun), int'(eu));
        start = do_start;
    endtask

    task automatic run_packet(input bit poke);
        int n = 0;
        feed = plan;
        step(1'b1);
        build_model();
        while (q_line.size() > 0) begin
            // R10: start pulse while busy must not disturb the waveform
            step(poke && (n == 200));
            n++;
        end
        feed.delete();
        pend = 1'b0;
        for (int k = 0; k < 6; k++) step(1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!line_out && !line_oe && !sym_ready && !underrun, "R1", "outputs in reset",
            int'({line_out, line_oe, sym_ready, underrun}), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!line_out && !line_oe && !sym_ready && !underrun, "R1", "outputs after reset",
            int'({line_out, line_oe, sym_ready, underrun}), 0);

        // ends low -> high/low closing edge, sym_last, start poke while busy
        plan = '{6'h15, 6'h00, 6'h3F};
        run_packet(1'b1);
        // one symbol then starvation, ends high -> low/low closing
        plan = '{6'h01};
        run_packet(1'b0);
        // starvation straight after the preamble
        plan.delete();
        run_packet(1'b1);
        // single final symbol
        plan = '{6'h2A};
        run_packet(1'b0);
        // one more symbol than the cap allows, none marked last
        plan.delete();
        for (int k = 0; k <= MAX_SYMS; k++) plan.push_back(6'(k % 32));
        run_packet(1'b0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL R2 watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule